// File: doc/BRIEF.md
# DMA Burst Request Controller

This block paces a device-side DMA port. Software loads a burst length in bytes, a total transfer length in bytes and a bus-width mode, then pulses a start input. The controller raises its request line and holds it while the external DMA engine performs bus cycles, each signalled by a one-clock strobe. Every strobe consumes one bus word: 2 bytes on a 16-bit bus, or 4 bytes on a 32-bit bus. The word is taken from both the current burst and the remaining transfer.

When a burst is used up, the request line drops for exactly one clock. It then rises again while bytes remain. When the transfer is exhausted, a done pulse is issued and the request stays low. A burst length of zero, a burst length not aligned to the bus width, or a transfer length of zero is refused: an error flag is raised and no request is issued. The smallest legal burst, one bus word, makes the request drop after every single bus cycle.

Top module: `dma_burst_req`

## Requirements
- R1: After reset `dreq`, `done` and `err` are all 0.
- R2: A `start` pulse sampled while idle with a legal configuration makes `dreq` 1 from the next clock edge.
- R3: Each clock with `dreq`=1 and `dma_strobe`=1 consumes one bus word. A word is 2 bytes when `mode32`=0 and 4 bytes when `mode32`=1. `dreq` falls after burst_bytes/word strobes, or earlier if the transfer runs out.
- R4: Between two bursts of the same transfer, `dreq` is 0 for exactly one clock and then returns to 1.
- R5: `done` is 1 for exactly one clock: the clock after the strobe that empties the transfer. In that clock `dreq` falls, and `dreq` stays 0 afterwards until a new start.
- R6: A burst of 2 bytes in 16-bit mode, or 4 bytes in 32-bit mode, makes `dreq` fall after every strobe.
- R7: The burst length is `burst_cfg` bits 12 to 0. Bits 15 to 13 are reserved and have no effect.
- R8: A start with a burst length of zero, a burst length that is odd in 16-bit mode, a burst length not a multiple of 4 in 32-bit mode, or a transfer length of zero sets `err` to 1 from the next clock edge. That start never raises `dreq`. The next legal start clears `err`.
- R9: A strobe arriving while `dreq` is 0 consumes nothing.
- R10: A `start` while a transfer is running is ignored. The running transfer keeps its burst length, length and mode.
- R11: A transfer shorter than the burst ends after length/word strobes in a single burst, with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer with the present configuration |
| burst_cfg | input | 16 | Burst length in bytes in bits 12:0; bits 15:13 reserved |
| xfer_bytes | input | BUF_W | Total transfer length in bytes |
| mode32 | input | 1 | 1 = 32-bit bus (4-byte words), 0 = 16-bit bus (2-byte words) |
| dma_strobe | input | 1 | One DMA bus cycle completed this clock |
| dreq | output | 1 | DMA request |
| done | output | 1 | One-clock pulse when the transfer is finished |
| err | output | 1 | Last start was refused for an illegal configuration |

## Verification
`dreq` rises at the first edge after an accepted start. `err` is valid at that same edge when a start is refused. A strobe sampled at one edge is counted, and when it closes a burst `dreq` falls at that very edge, with `done` alongside if the transfer is emptied. The next rise comes one edge later. The bench drives inputs just after a rising edge and samples at the falling edge, so each counted strobe and each level change falls in a known half-period. The scoreboard pairs every observed fall of `dreq` with a precomputed expected burst length and last-burst flag.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

  localparam int DBR_BURST_W = 13;
  localparam int DBR_CFG_W   = 16;
  localparam int DBR_STEP_W  = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_GAP  = 2'd2
  } dbr_state_e;

  // bytes carried by one bus cycle
  function automatic logic [DBR_STEP_W-1:0] dbr_step(input logic wide);
    return wide ? 3'd4 : 3'd2;
  endfunction

  // burst length is nonzero and a whole number of bus words
  function automatic logic dbr_burst_legal(input logic [DBR_BURST_W-1:0] len,
                                           input logic wide);
    logic aligned;
    aligned = wide ? (len[1:0] == 2'b00) : (len[0] == 1'b0);
    return (len != '0) && aligned;
  endfunction

endpackage

// File: rtl/dbr_cfg_check.sv
module dbr_cfg_check
  import dbr_pkg::*;
#(
  parameter int BUF_W = 20
) (
  input  logic [DBR_BURST_W-1:0] burst_len,
  input  logic [BUF_W-1:0]       total_len,
  input  logic                   wide,
  output logic                   cfg_ok
);

  logic burst_fine;
  logic total_fine;

  assign burst_fine = dbr_burst_legal(burst_len, wide);
  assign total_fine = (total_len != '0);
  assign cfg_ok     = burst_fine && total_fine;

endmodule

// File: rtl/dbr_down_counter.sv
module dbr_down_counter
  import dbr_pkg::*;
#(
  parameter int W = 13
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [W-1:0]          load_val,
  input  logic                  dec,
  input  logic [DBR_STEP_W-1:0] step,
  output logic [W-1:0]          count,
  output logic                  last_word
);

  logic [W-1:0] step_w;

  assign step_w    = W'(step);
  assign last_word = (count <= step_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (dec) begin
      count <= last_word ? '0 : (count - step_w);
    end
  end

endmodule

// File: rtl/dbr_seq.sv
module dbr_seq
  import dbr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       cfg_ok,
  input  logic       strobe,
  input  logic       burst_last,
  input  logic       remain_last,
  output dbr_state_e state,
  output logic       accept,
  output logic       launch,
  output logic       consume,
  output logic       burst_end,
  output logic       xfer_end,
  output logic       dreq,
  output logic       done,
  output logic       err
);

  dbr_state_e state_nx;

  assign accept    = (state == ST_IDLE) && start;
  assign launch    = accept && cfg_ok;
  assign consume   = (state == ST_REQ) && strobe;
  assign xfer_end  = consume && remain_last;
  assign burst_end = consume && burst_last && !remain_last;
  assign dreq      = (state == ST_REQ);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (launch) state_nx = ST_REQ;
      ST_REQ: begin
        if (xfer_end)       state_nx = ST_IDLE;
        else if (burst_end) state_nx = ST_GAP;
      end
      ST_GAP:  state_nx = ST_REQ;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      state <= state_nx;
      done  <= xfer_end;
      if (accept) err <= !cfg_ok;
    end
  end

endmodule

// File: rtl/dma_burst_req.sv
module dma_burst_req
  import dbr_pkg::*;
#(
  parameter int BUF_W = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [DBR_CFG_W-1:0] burst_cfg,
  input  logic [BUF_W-1:0]     xfer_bytes,
  input  logic                 mode32,
  input  logic                 dma_strobe,
  output logic                 dreq,
  output logic                 done,
  output logic                 err
);

  logic [DBR_BURST_W-1:0] burst_field;
  logic [DBR_BURST_W-1:0] burst_q;
  logic                   mode_q;
  logic [DBR_STEP_W-1:0]  step;
  logic                   cfg_ok;
  logic                   accept;
  logic                   launch;
  logic                   consume;
  logic                   burst_end;
  logic                   xfer_end;
  logic                   burst_last;
  logic                   remain_last;
  logic                   burst_load;
  logic [DBR_BURST_W-1:0] burst_load_val;
  logic [DBR_BURST_W-1:0] burst_left;
  logic [BUF_W-1:0]       remain_left;
  dbr_state_e             state;

  assign burst_field = burst_cfg[DBR_BURST_W-1:0];
  assign step        = dbr_step(mode_q);

  dbr_cfg_check #(.BUF_W(BUF_W)) u_cfg (
    .burst_len (burst_field),
    .total_len (xfer_bytes),
    .wide      (mode32),
    .cfg_ok    (cfg_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_q <= '0;
      mode_q  <= 1'b0;
    end else if (launch) begin
      burst_q <= burst_field;
      mode_q  <= mode32;
    end
  end

  assign burst_load     = launch || burst_end;
  assign burst_load_val = launch ? burst_field : burst_q;

  dbr_down_counter #(.W(DBR_BURST_W)) u_burst_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (burst_load),
    .load_val  (burst_load_val),
    .dec       (consume),
    .step      (step),
    .count     (burst_left),
    .last_word (burst_last)
  );

  dbr_down_counter #(.W(BUF_W)) u_remain_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (launch),
    .load_val  (xfer_bytes),
    .dec       (consume),
    .step      (step),
    .count     (remain_left),
    .last_word (remain_last)
  );

  dbr_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .cfg_ok      (cfg_ok),
    .strobe      (dma_strobe),
    .burst_last  (burst_last),
    .remain_last (remain_last),
    .state       (state),
    .accept      (accept),
    .launch      (launch),
    .consume     (consume),
    .burst_end   (burst_end),
    .xfer_end    (xfer_end),
    .dreq        (dreq),
    .done        (done),
    .err         (err)
  );

endmodule

// File: rtl/dbr_checker.sv
module dbr_checker
  import dbr_pkg::*;
#(
  parameter int BUF_W = 20
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic [DBR_CFG_W-1:0]   burst_cfg,
  input logic [BUF_W-1:0]       xfer_bytes,
  input logic                   mode32,
  input logic                   dma_strobe,
  input logic                   dreq,
  input logic                   done,
  input logic                   err,
  input logic                   launch,
  input logic                   consume,
  input logic [DBR_BURST_W-1:0] burst_q,
  input logic                   mode_q,
  input logic [BUF_W-1:0]       remain_left
);

  logic idle_seen;
  logic min_burst;

  assign idle_seen = !dreq && !done;
  assign min_burst = mode_q ? (burst_q == 13'd4) : (burst_q == 13'd2);

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (!dreq && !err)); // R1

  AST_LAUNCH_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> dreq); // R2

  AST_FALL_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dreq) |-> $past(dma_strobe)); // R3

  AST_REMAIN_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    !launch |=> (remain_left <= $past(remain_left))); // R3

  AST_GAP_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dreq) && !done) |=> dreq); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5

  AST_DONE_NO_DREQ: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !dreq); // R5

  AST_MIN_BURST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && min_burst) |=> !dreq); // R6

  AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_seen && start && (burst_cfg[15:13] != 3'b000) && (xfer_bytes != '0)
     && dbr_burst_legal(burst_cfg[12:0], mode32)) |=> dreq); // R7

  AST_ERR_NO_DREQ: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !dreq); // R8

  AST_IDLE_STROBE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (!dreq && !launch) |=> $stable(remain_left)); // R9

endmodule

bind dma_burst_req dbr_checker #(.BUF_W(BUF_W)) i_dbr_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .burst_cfg   (burst_cfg),
  .xfer_bytes  (xfer_bytes),
  .mode32      (mode32),
  .dma_strobe  (dma_strobe),
  .dreq        (dreq),
  .done        (done),
  .err         (err),
  .launch      (launch),
  .consume     (consume),
  .burst_q     (burst_q),
  .mode_q      (mode_q),
  .remain_left (remain_left)
);

// File: tb/test_dma_burst_req.sv
`timescale 1ns/1ps
module test_dma_burst_req;

  localparam int BUF_W = 20;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [15:0]      burst_cfg = '0;
  logic [BUF_W-1:0] xfer_bytes = '0;
  logic             mode32 = 1'b0;
  logic             dma_strobe = 1'b0;
  logic             dreq;
  logic             done;
  logic             err;

  always #2 clk = ~clk;

  dma_burst_req #(.BUF_W(BUF_W)) i_dma_burst_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .burst_cfg  (burst_cfg),
    .xfer_bytes (xfer_bytes),
    .mode32     (mode32),
    .dma_strobe (dma_strobe),
    .dreq       (dreq),
    .done       (done),
    .err        (err)
  );

  typedef struct {
    int strobes;
    bit last;
  } burst_item_t;

  burst_item_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit done_seen = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: counts strobes per burst and pops the scoreboard on each fall
  int  hits = 0;
  int  low_run = 0;
  bit  prev_dreq = 1'b0;
  bit  after_last = 1'b1;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (prev_dreq && !dreq) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected burst end", hits, 0);
        end else begin
          burst_item_t it;
          it = exp_q.pop_front();
          chk(hits == it.strobes, "R3 strobes per burst", hits, it.strobes);
          chk(done == it.last, "R5 done at final fall", int'(done), int'(it.last));
        end
        hits = 0;
        low_run = 0;
        after_last = done;
        if (done) done_seen = 1'b1;
      end
      if (!dreq) low_run++;
      if (!prev_dreq && dreq) begin
        if (!after_last) chk(low_run == 1, "R4 gap length", low_run, 1);
        low_run = 0;
      end
      if (dreq && dma_strobe) hits++;
      prev_dreq = dreq;
    end
  end

  // driver: pushes expected bursts, then runs the transfer
  task automatic run_xfer(input logic [15:0] cfg, input int total, input bit wide,
                          input bit strobe_always, input bit poke_start, input string tag);
    int word;
    int blen;
    int rem;
    int cyc;
    word = wide ? 4 : 2;
    blen = int'(cfg[12:0]);
    rem  = total;
    while (rem > 0) begin
      burst_item_t it;
      it.strobes = ((rem < blen) ? rem : blen) / word;
      it.last    = (rem <= blen);
      exp_q.push_back(it);
      rem -= blen;
    end
    done_seen = 1'b0;
    @(posedge clk); #1;
    burst_cfg = cfg; xfer_bytes = BUF_W'(total); mode32 = wide; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    chk(dreq == 1'b1, {"R2 dreq after start ", tag}, int'(dreq), 1);
    chk(err == 1'b0, {"R8 err clear on legal start ", tag}, int'(err), 0);
    cyc = 0;
    while (!done_seen && cyc < 4000) begin
      @(posedge clk); #1;
      dma_strobe = strobe_always ? 1'b1 : dreq;
      if (poke_start && cyc == 3) begin
        start = 1'b1; burst_cfg = 16'd4; xfer_bytes = BUF_W'(4); mode32 = ~wide;  // R10
      end else begin
        start = 1'b0;
      end
      cyc++;
    end
    dma_strobe = 1'b0;
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk(dreq == 1'b0, {"R5 dreq stays low after done ", tag}, int'(dreq), 0);
    chk(exp_q.size() == 0, {"R5 all bursts seen ", tag}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic run_bad(input logic [15:0] cfg, input int total, input bit wide,
                         input string tag);
    int highs;
    @(posedge clk); #1;
    burst_cfg = cfg; xfer_bytes = BUF_W'(total); mode32 = wide; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    dma_strobe = 1'b1;
    @(negedge clk);
    chk(err == 1'b1, {"R8 err set ", tag}, int'(err), 1);
    highs = 0;
    repeat (6) begin
      @(negedge clk);
      if (dreq) highs++;
    end
    chk(highs == 0, {"R8 no dreq ", tag}, highs, 0);
    @(posedge clk); #1;
    dma_strobe = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dreq == 1'b0 && done == 1'b0 && err == 1'b0, "R1 reset outputs",
        int'({dreq, done, err}), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    run_xfer(16'd8,    32, 1'b0, 1'b0, 1'b0, "16b");           // R3 R4 R5
    run_xfer(16'd16,   64, 1'b1, 1'b0, 1'b0, "32b");           // R3
    run_xfer(16'd2,     8, 1'b0, 1'b0, 1'b0, "min16");         // R6
    run_xfer(16'd4,    12, 1'b1, 1'b0, 1'b0, "min32");         // R6
    run_xfer(16'hE008, 16, 1'b0, 1'b0, 1'b0, "reserved");      // R7
    run_xfer(16'd8,    24, 1'b0, 1'b1, 1'b0, "strobe_gap");    // R9
    run_xfer(16'd16,    6, 1'b0, 1'b0, 1'b0, "short");         // R11
    run_xfer(16'd8,    32, 1'b1, 1'b0, 1'b1, "restart");       // R10
    run_bad(16'd0,     16, 1'b0, "zero burst");
    run_bad(16'd3,     12, 1'b0, "odd burst 16b");
    run_bad(16'd6,     24, 1'b1, "burst 6 in 32b");
    run_bad(16'd8,      0, 1'b0, "zero length");
    run_xfer(16'd12,   24, 1'b1, 1'b0, 1'b0, "after err");     // R8 clear
    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule